// File: doc/BRIEF.md
# Partitioned SIMD Variable Shifter

This block shifts the packed lanes of a 64-bit operand. The operand is read either as four 16-bit lanes or as two 32-bit lanes. Each lane has its own shift count, which comes from the matching lane of a second 64-bit operand. Four kinds of shift are available: logical left, logical right, arithmetic right, and a saturating arithmetic left shift. The saturating shift clamps each lane to its signed range and does not drop the bits that overflow.

A 9-bit operation code selects both the lane width and the shift kind. The block decodes this code itself. Any code outside the eight supported ones raises an `illegal` flag and forces the result to zero.

The output can be registered or left combinational, as set by a parameter. When registered, the result and the flags appear one clock after the input strobe.

Top module: `lane_shift_unit`

## Requirements
- R1: In narrow mode, lane i of `srcA` and `srcB` is bits [16i+15:16i], for i = 0 to 3. In wide mode, lane i is bits [32i+31:32i], for i = 0 to 1. The result uses the same lane layout.
- R2: A lane's shift count is the low 4 bits (narrow mode) or the low 5 bits (wide mode) of the matching `srcB` lane. All other `srcB` bits have no effect.
- R3: Logical left (0x021 narrow, 0x025 wide) keeps only the low lane-width bits of the shifted lane. It never saturates.
- R4: Logical right (0x023 narrow, 0x027 wide) fills the vacated high bits with zeros.
- R5: Arithmetic right (0x02B narrow, 0x02F wide) fills the vacated high bits with copies of the lane's sign bit.
- R6: Saturating left (0x029 narrow, 0x02D wide) works in three steps:
  - It sign-extends the lane and shifts it without losing bits.
  - It clamps the exact value to the lane's signed range: [-32768, 32767] for narrow lanes, [-2^31, 2^31-1] for wide lanes.
  - A negative lane that overflows goes to the signed minimum, so the sign of every lane is kept.
- R7: A shift count of zero passes a lane through unchanged in every mode. Saturating left by zero never clamps.
- R8: In the code set, bit 2 selects wide lanes, bit 1 selects a right shift, and bit 3 selects arithmetic or saturating behaviour. Any other code gives `illegal` = 1 together with the strobe, and a result of zero.
- R9: With `REG_OUT` = 1, `outValid`, `result` and `illegal` show the inputs of the previous clock. After reset all three are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and code are valid this cycle |
| opCode | input | 9 | Operation code |
| srcA | input | 64 | Packed lanes to shift |
| srcB | input | 64 | Packed per-lane shift counts |
| outValid | output | 1 | Result strobe |
| result | output | 64 | Shifted lanes |
| illegal | output | 1 | Operation code not supported |

## Verification
The clocked assertions assume that `opCode`, `srcA` and `srcB` hold steady through the whole cycle in which `inValid` is high. They also assume that the registered variant is in use. The bench meets both conditions:
- It changes every input only on the falling clock edge.
- It keeps the default `REG_OUT` = 1.

Legal codes come from a fixed list of eight. Random codes then probe the illegal path. Directed lanes set near the clamp edges test both sides of each saturation boundary.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;
  localparam int DATA_W = 64;
  localparam int OPC_W = 9;
  localparam int NARROW_W = 16;
  localparam int WIDE_W = 32;

  typedef struct packed {
    logic legal;
    logic wide;
    logic right;
    logic arith;
  } shiftCtrl_t;
endpackage

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic [OPC_W-1:0] opCode,
  output shiftCtrl_t       ctrl
);
  // Supported set: upper field 5'b00010 with bit 0 set; bits 3..1 choose the operation.
  always_comb begin
    ctrl.legal = (opCode[OPC_W-1:4] == 5'b00010) && opCode[0];
    ctrl.wide  = opCode[2];
    ctrl.right = opCode[1];
    ctrl.arith = opCode[3];
  end
endmodule

// File: rtl/lane_shift_lane.sv
module lane_shift_lane #(
  parameter int LANE_W = 16
) (
  input  logic              right,
  input  logic              arith,
  input  logic [LANE_W-1:0] laneA,
  input  logic [$clog2(LANE_W)-1:0] cnt,
  output logic [LANE_W-1:0] laneY
);
  localparam int EXT_W = 2 * LANE_W;

  logic signed [LANE_W-1:0] signedA;
  logic signed [EXT_W-1:0]  extA;
  logic signed [EXT_W-1:0]  exact;
  logic [LANE_W:0]          topBits;
  logic                     fits;
  logic [LANE_W-1:0]        satVal;

  assign signedA = laneA;
  assign extA    = {{LANE_W{laneA[LANE_W-1]}}, laneA};
  assign exact   = extA <<< cnt;
  assign topBits = exact[EXT_W-1:LANE_W-1];
  assign fits    = (&topBits) | ~(|topBits);

  always_comb begin
    if (fits) satVal = exact[LANE_W-1:0];
    else if (exact[EXT_W-1]) satVal = {1'b1, {(LANE_W-1){1'b0}}};
    else satVal = {1'b0, {(LANE_W-1){1'b1}}};
  end

  always_comb begin
    unique case ({arith, right})
      2'b00:   laneY = laneA << cnt;
      2'b01:   laneY = laneA >> cnt;
      2'b10:   laneY = satVal;
      default: laneY = signedA >>> cnt;
    endcase
  end
endmodule

// File: rtl/lane_shift_dp.sv
module lane_shift_dp
  import lane_shift_pkg::*;
(
  input  shiftCtrl_t        ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] dpOut
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;
  localparam int CNT_N    = $clog2(NARROW_W);
  localparam int CNT_W    = $clog2(WIDE_W);

  logic [DATA_W-1:0] narrowOut;
  logic [DATA_W-1:0] wideOut;
  logic              unusedCountBits;

  assign unusedCountBits = ^srcB;

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    lane_shift_lane #(.LANE_W(NARROW_W)) uLane (
      .right (ctrl.right),
      .arith (ctrl.arith),
      .laneA (srcA[i*NARROW_W +: NARROW_W]),
      .cnt   (srcB[i*NARROW_W +: CNT_N]),
      .laneY (narrowOut[i*NARROW_W +: NARROW_W])
    );
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    lane_shift_lane #(.LANE_W(WIDE_W)) uLane (
      .right (ctrl.right),
      .arith (ctrl.arith),
      .laneA (srcA[i*WIDE_W +: WIDE_W]),
      .cnt   (srcB[i*WIDE_W +: CNT_W]),
      .laneY (wideOut[i*WIDE_W +: WIDE_W])
    );
  end

  always_comb begin
    if (!ctrl.legal) dpOut = '0;
    else if (ctrl.wide) dpOut = wideOut;
    else dpOut = narrowOut;
  end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lane_shift_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  shiftCtrl_t        ctrl;
  logic [DATA_W-1:0] dpOut;

  lane_shift_ctrl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  lane_shift_dp uDp (
    .ctrl  (ctrl),
    .srcA  (srcA),
    .srcB  (srcB),
    .dpOut (dpOut)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid <= 1'b0;
        result   <= '0;
        illegal  <= 1'b0;
      end else begin
        outValid <= inValid;
        result   <= dpOut;
        illegal  <= inValid & ~ctrl.legal;
      end
    end

    // R9: strobe follows the input one clock later
    a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    a_r9_idle_delay: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    // R8: unsupported code flags and zeroes the result
    a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !ctrl.legal) |=> (illegal && result == '0));
    // R7: zero counts pass lanes through
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && ctrl.legal && srcB == '0) |=> (result == $past(srcA)));
    // R6: saturating left keeps the sign of narrow lane 0
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && ctrl.legal && ctrl.arith && !ctrl.right && !ctrl.wide)
      |=> (result[NARROW_W-1] == $past(srcA[NARROW_W-1])));
  end else begin : g_comb
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
    assign outValid  = inValid;
    assign result    = dpOut;
    assign illegal   = inValid & ~ctrl.legal;
  end
endmodule

// File: tb/lane_shift_unit_test.sv
`timescale 1ns/1ps
module lane_shift_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [8:0]  opCode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_shift_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result),
    .illegal(illegal)
  );

  function automatic bit isLegal(input logic [8:0] op);
    case (op)
      9'h021, 9'h023, 9'h025, 9'h027, 9'h029, 9'h02B, 9'h02D, 9'h02F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    int w, n, cnt;
    longint sv, mx, mn;
    longint unsigned uv, mask;
    r = '0;
    if (!isLegal(op)) return r;
    w = (op == 9'h025 || op == 9'h027 || op == 9'h02D || op == 9'h02F) ? 32 : 16;
    n = 64 / w;
    mask = (64'd1 << w) - 1;
    mx = (64'sd1 <<< (w - 1)) - 1;
    mn = -(64'sd1 <<< (w - 1));
    for (int i = 0; i < n; i++) begin
      uv = (a >> (i * w)) & mask;
      sv = longint'(uv);
      if (uv[w-1]) sv = sv - (64'sd1 <<< w);
      cnt = int'((b >> (i * w)) % w);
      case (op)
        9'h021, 9'h025: uv = (uv << cnt) & mask;
        9'h023, 9'h027: uv = uv >> cnt;
        9'h02B, 9'h02F: uv = longint'(sv >>> cnt) & mask;
        default: begin
          sv = sv <<< cnt;
          if (sv > mx) sv = mx;
          if (sv < mn) sv = mn;
          uv = sv & mask;
        end
      endcase
      r = r | (uv << (i * w));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input string req, input logic [8:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    inValid = 1'b1; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " result"}, result, model(op, a, b));
    chk({req, " illegal"}, {63'd0, illegal}, {63'd0, !isLegal(op)});
    chk({req, " R9 valid"}, {63'd0, outValid}, 64'd1);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] ops [8];
    ops = '{9'h021, 9'h023, 9'h025, 9'h027, 9'h029, 9'h02B, 9'h02D, 9'h02F};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R9 reset outValid", {63'd0, outValid}, 64'd0);
    chk("R9 reset result", result, 64'd0);
    chk("R9 reset illegal", {63'd0, illegal}, 64'd0);
    rstN = 1'b1;
    // R1 lane layout and R3 logical left truncation
    doOp("R1_R3 sll16", 9'h021, 64'h8001_4001_00FF_1234, 64'h0001_0002_0008_0004);
    doOp("R3 sll32", 9'h025, 64'h8000_0001_1234_5678, 64'h0000_0001_0000_0010);
    // R4 and R5 at maximum counts
    doOp("R4 srl16 max", 9'h023, 64'h8000_FFFF_8000_7FFF, 64'h000F_000F_000F_000F);
    doOp("R5 sra16 max", 9'h02B, 64'h8000_FFFF_8000_7FFF, 64'h000F_000F_000F_000F);
    doOp("R5 sra32 max", 9'h02F, 64'h8000_0000_7FFF_FFFF, 64'h0000_001F_0000_001F);
    doOp("R4 srl32 max", 9'h027, 64'h8000_0000_7FFF_FFFF, 64'h0000_001F_0000_001F);
    // R2 upper count bits ignored
    doOp("R2 count bits16", 9'h023, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFF1_0010_FFE2_7FF3);
    doOp("R2 count bits32", 9'h025, 64'h0000_0003_0000_0005, 64'hFFFF_FFE1_0000_0020);
    // R6 saturation boundaries
    doOp("R6 sat16 edge", 9'h029, 64'h3FFF_BFFF_C000_4000, 64'h0001_0001_0001_0001);
    doOp("R6 sat16 neg", 9'h029, 64'h8000_FFFF_8001_0001, 64'h0001_000F_000F_000F);
    doOp("R6 sat32 edge", 9'h02D, 64'h8000_0000_0000_0001, 64'h0000_0001_0000_001F);
    doOp("R6 sat32 neg", 9'h02D, 64'hC000_0000_BFFF_FFFF, 64'h0000_0001_0000_0001);
    // R7 zero counts in every mode
    foreach (ops[k]) doOp("R7 zero count", ops[k], 64'h8000_7FFF_8001_FFFF, 64'h0);
    // R8 illegal codes
    doOp("R8 illegal", 9'h020, 64'h1234_5678_9ABC_DEF0, 64'h1);
    doOp("R8 illegal", 9'h1A1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    doOp("R8 illegal", 9'h022, 64'h1, 64'h0);
    // R9 idle cycle drops the strobe
    @(negedge clk);
    chk("R9 idle outValid", {63'd0, outValid}, 64'd0);
    // random legal traffic (R1..R6)
    for (int i = 0; i < 400; i++) begin
      doOp("R1 random", ops[$urandom_range(0, 7)],
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    for (int i = 0; i < 40; i++) begin
      doOp("R8 random code", 9'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule